// File: doc/BRIEF.md
# Timer Compare Match Unit

This block watches a free-running timer count and compares it, at full width, against a programmed compare value on every clock. When the two are equal, a mode register decides what happens. The output latch can be set high or cleared low, or it can be left untouched while only the interrupt flag is raised. In trigger mode the block emits a one-cycle strobe that resets the external timer, which turns the compare value into a programmable timer period. On a channel built with conversion support, the same trigger can also fire a conversion-start strobe when the converter is enabled.

The pin is driven only while the active-low tristate input is low. The interrupt flag is sticky and is cleared by a software strobe. A match is acted on once for each timer value, so a stalled timer cannot repeat the action. The trigger strobe is separate from any timer overflow indication, so a trigger-driven timer reset never appears as an overflow. The timer and the converter are outside this block.

Top module: `cmp_match_unit`

## Requirements
- R1: A match requires all TMR_W bits of the timer value to equal the compare value. A timer value that differs only in its most significant bit produces no action.
- R2: With mode code 4'b1000, a match in cycle N drives pin_out to 1 after the clock edge that ends cycle N.
- R3: A match in any of the modes 4'b1000, 4'b1001, 4'b1010 or 4'b1011 sets cmp_flag after the same edge that performs the pin action. cmp_flag stays set until a flag_clr strobe. When a new match and flag_clr arrive in the same cycle, the set wins.
- R4: With mode code 4'b1010, a match sets cmp_flag and leaves pin_out unchanged.
- R5: With mode code 4'b1011, a match produces tmr_rst high for exactly the cycle after the match cycle and leaves pin_out unchanged.
- R6: conv_start pulses together with tmr_rst only when HAS_CONV is 1 and conv_en was high in the match cycle. Otherwise it stays low.
- R7: With mode code 4'b1001, a match in cycle N drives pin_out to 0 after the edge that ends cycle N.
- R8: Writing mode code 4'b0000 forces pin_out to 0 after the write edge. Writing any other code leaves pin_out as it was.
- R9: A timer value held across several cycles produces only one action. A new action needs the timer value to change and match again.
- R10: pin_oe is 1 exactly while pin_tris_n is 0.
- R11: Mode codes other than the four active ones (for example 4'b0000 or 4'b1100) take no action on a match: no flag, no pin change, no strobe.
- R12: After reset, pin_out, cmp_flag, tmr_rst and conv_start are 0, and the mode register holds 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_val | input | TMR_W | Current timer count |
| cmp_wr_en | input | 1 | Write strobe for the compare value |
| cmp_wr_data | input | TMR_W | New compare value |
| mode_wr_en | input | 1 | Write strobe for the mode register |
| mode_wr_data | input | MODE_W | New mode code |
| flag_clr | input | 1 | Software clear strobe for the interrupt flag |
| pin_tris_n | input | 1 | Active-low tristate control for the pin |
| conv_en | input | 1 | Converter enable, which gates conv_start |
| pin_out | output | 1 | Compare output latch |
| pin_oe | output | 1 | Pin output enable |
| cmp_flag | output | 1 | Sticky compare interrupt flag |
| tmr_rst | output | 1 | One-cycle timer reset strobe from the trigger |
| conv_start | output | 1 | One-cycle conversion-start strobe |

## Verification
The bench builds the block with its defaults: a 16-bit timer and HAS_CONV set to 1. The full width lets a stimulus differ from the compare value only in bit 15, which checks that every bit takes part in the match. With conversion support present, the bench can reach both sides of the converter-enable gate in trigger mode. It also reaches the same-cycle race between a new match and a flag clear, which the design resolves in favour of the set.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] CM_OFF  = 4'b0000;
    localparam logic [MODE_W-1:0] CM_SET  = 4'b1000;
    localparam logic [MODE_W-1:0] CM_CLR  = 4'b1001;
    localparam logic [MODE_W-1:0] CM_SWI  = 4'b1010;
    localparam logic [MODE_W-1:0] CM_TRIG = 4'b1011;

    typedef struct packed {
        logic drive_hi;
        logic drive_lo;
        logic raise_flag;
        logic fire_trig;
    } cmp_action_t;
endpackage

// File: rtl/cmp_detect.sv
module cmp_detect #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic [TMR_W-1:0] cmp_val,
    output logic             evt
);
    typedef struct packed {
        logic [TMR_W-1:0] last_tmr;
        logic             hit;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       eq;

    always_comb begin
        eq            = (tmr_val == cmp_val);
        evt           = eq && (!st_q.hit || (tmr_val != st_q.last_tmr));
        st_d          = st_q;
        st_d.last_tmr = tmr_val;
        st_d.hit      = eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: an event is never repeated while the timer value is unchanged
    p_once_per_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !(evt && $stable(tmr_val)));
endmodule

// File: rtl/cmp_decode.sv
module cmp_decode
    import cmp_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              evt,
    output cmp_action_t       act
);
    always_comb begin
        act = '0;
        if (evt) begin
            unique case (mode)
                CM_SET: begin
                    act.drive_hi   = 1'b1;
                    act.raise_flag = 1'b1;
                end
                CM_CLR: begin
                    act.drive_lo   = 1'b1;
                    act.raise_flag = 1'b1;
                end
                CM_SWI: begin
                    act.raise_flag = 1'b1;
                end
                CM_TRIG: begin
                    act.raise_flag = 1'b1;
                    act.fire_trig  = 1'b1;
                end
                default: act = '0;
            endcase
        end
    end

    // R11: the off code never yields an action
    always_comb begin
        if (mode == CM_OFF) begin
            a_off_no_action_r11: assert (act == '0);
        end
    end
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
    import cmp_pkg::*;
#(
    parameter int TMR_W    = 16,
    parameter bit HAS_CONV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] tmr_val,
    input  logic             cmp_wr_en,
    input  logic [TMR_W-1:0] cmp_wr_data,
    input  logic             mode_wr_en,
    input  logic [3:0]       mode_wr_data,
    input  logic             flag_clr,
    input  logic             pin_tris_n,
    input  logic             conv_en,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             cmp_flag,
    output logic             tmr_rst,
    output logic             conv_start
);
    typedef struct packed {
        logic [TMR_W-1:0]  cmp;
        logic [MODE_W-1:0] mode;
        logic              latch;
        logic              flag;
        logic              trig;
        logic              conv;
    } unit_state_t;

    unit_state_t st_d, st_q;
    logic        evt;
    cmp_action_t act;
    logic        conv_ok;

    cmp_detect #(.TMR_W(TMR_W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .tmr_val (tmr_val),
        .cmp_val (st_q.cmp),
        .evt     (evt)
    );

    cmp_decode u_decode (
        .mode (st_q.mode),
        .evt  (evt),
        .act  (act)
    );

    generate
        if (HAS_CONV) begin : g_conv
            assign conv_ok = conv_en;
        end else begin : g_noconv
            logic unused_conv_en;
            assign unused_conv_en = conv_en;
            assign conv_ok        = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (cmp_wr_en) begin
            st_d.cmp = cmp_wr_data;
        end
        if (mode_wr_en) begin
            st_d.mode = mode_wr_data;
        end
        if (mode_wr_en && (mode_wr_data == CM_OFF)) begin
            st_d.latch = 1'b0;
        end else if (act.drive_hi) begin
            st_d.latch = 1'b1;
        end else if (act.drive_lo) begin
            st_d.latch = 1'b0;
        end
        if (act.raise_flag) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        st_d.trig = act.fire_trig;
        st_d.conv = act.fire_trig && conv_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out    = st_q.latch;
    assign pin_oe     = ~pin_tris_n;
    assign cmp_flag   = st_q.flag;
    assign tmr_rst    = st_q.trig;
    assign conv_start = st_q.conv;

    // R3: an acting match raises the flag on the next edge
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && act.raise_flag) |=> cmp_flag);
    // R3: the flag holds without a clear strobe
    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);
    // R4: interrupt-only mode keeps the pin
    p_swi_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && st_q.mode == CM_SWI && !mode_wr_en) |=> $stable(pin_out));
    // R5: a timer reset strobe only follows a trigger-mode match
    p_trig_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_rst |-> ($past(evt) && $past(st_q.mode) == CM_TRIG));
    // R6: conversion start only accompanies the trigger
    p_conv_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> tmr_rst);
    // R8: writing the off code clears the latch
    p_zero_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr_en && mode_wr_data == CM_OFF) |=> !pin_out);
    // R11: inactive codes leave the pin alone
    p_other_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !act.raise_flag && !mode_wr_en) |=> $stable(pin_out));
endmodule

// File: tb/cmp_match_unit_tb.sv
module cmp_match_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        bit    chk;
        bit    ep, ef, er, ec, eo;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmr_val = '0;
    logic        cmp_wr_en = 1'b0;
    logic [15:0] cmp_wr_data = '0;
    logic        mode_wr_en = 1'b0;
    logic [3:0]  mode_wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        pin_tris_n = 1'b1;
    logic        conv_en = 1'b0;
    logic        pin_out, pin_oe, cmp_flag, tmr_rst, conv_start;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_match_unit #(.TMR_W(16), .HAS_CONV(1'b1)) dut_i (
        .clk, .rst_n, .tmr_val, .cmp_wr_en, .cmp_wr_data, .mode_wr_en,
        .mode_wr_data, .flag_clr, .pin_tris_n, .conv_en,
        .pin_out, .pin_oe, .cmp_flag, .tmr_rst, .conv_start
    );

    task automatic cyc(input logic [15:0] t, input bit cw, input logic [15:0] cd,
                       input bit mw, input logic [3:0] md, input bit clr,
                       input bit tris, input bit cen, input bit chk,
                       input bit ep, input bit ef, input bit er, input bit ec,
                       input string tag);
        exp_t e;
        @(negedge clk);
        tmr_val = t; cmp_wr_en = cw; cmp_wr_data = cd;
        mode_wr_en = mw; mode_wr_data = md; flag_clr = clr;
        pin_tris_n = tris; conv_en = cen;
        e.chk = chk; e.ep = ep; e.ef = ef; e.er = er; e.ec = ec;
        e.eo = !tris; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.chk) begin
                n_run++;
                if ({pin_out, cmp_flag, tmr_rst, conv_start, pin_oe} !==
                    {e.ep, e.ef, e.er, e.ec, e.eo}) begin
                    n_fail++;
                    $display("FAIL %s: pin/flag/rst/conv/oe got %b%b%b%b%b expected %b%b%b%b%b",
                             e.tag, pin_out, cmp_flag, tmr_rst, conv_start, pin_oe,
                             e.ep, e.ef, e.er, e.ec, e.eo);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state, R10 pin not driven while tris high
        cyc(16'h0005, 1, 16'h1234, 1, 4'b1000, 0, 1, 0, 1, 0, 0, 0, 0, "R12");
        // R1 only the top bit differs
        cyc(16'h9234, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R1");
        // R2 set on match, R3 flag, R10 oe
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R2");
        // R9 held value, clear accepted
        cyc(16'h1234, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0, "R9");
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R9");
        cyc(16'h1235, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R3");
        // R8 non-zero mode write keeps the latch
        cyc(16'h1235, 0, 0, 1, 4'b1001, 0, 0, 0, 1, 1, 0, 0, 0, "R8");
        // R7 clear on match
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R7");
        cyc(16'h1235, 0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R3");
        // R3 set beats a same-cycle clear
        cyc(16'h1234, 0, 0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 0, "R3");
        cyc(16'h0000, 0, 0, 1, 4'b1000, 0, 0, 0, 1, 0, 1, 0, 0, "R3");
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R2");
        cyc(16'h0000, 0, 0, 1, 4'b1010, 1, 0, 0, 1, 1, 0, 0, 0, "R8");
        // R4 interrupt only
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R4");
        cyc(16'h0000, 0, 0, 1, 4'b1011, 1, 0, 0, 1, 1, 0, 0, 0, "R4");
        // R5 trigger, R6 converter disabled
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, "R5");
        cyc(16'h0000, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R5");
        // R6 converter enabled
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, "R6");
        cyc(16'h0001, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, "R6");
        // R11 unused code
        cyc(16'h0000, 0, 0, 1, 4'b1100, 1, 0, 0, 1, 1, 0, 0, 0, "R11");
        cyc(16'h1234, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R11");
        // R8 zero write forces the latch low
        cyc(16'h0000, 0, 0, 1, 4'b0000, 0, 0, 0, 1, 0, 0, 0, 0, "R8");
        cyc(16'h1234, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0, "R11");
        cyc(16'h0000, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "");
        wait (sb.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule